// File: doc/BRIEF.md
# TDM Audio Frame Receiver

This block takes a time-division-multiplexed audio stream on one serial data line and turns it into parallel samples. The bit clock is the block's own clock, and a frame-sync line marks where each frame begins. Every frame is cut into 32-clock slots. The first 24 bits of each slot are a sample, sent most significant bit first. The block delivers each finished sample as a 24-bit word, together with a channel index and a one-cycle valid strobe.

A rate input picks one of two frame layouts. In single rate a frame is 256 clocks long and carries eight slots. In dual rate a frame is 128 clocks long and carries four slots. The receiver counts bit positions from every rising edge of the frame-sync line. When that edge arrives anywhere other than exactly one frame after the previous one, the receiver raises a sticky framing-error flag and restarts its count from the new edge.

Top module: `tdm_rx`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released, `valid_o` and `frame_err_o` are 0. A reset also clears a framing error that was set earlier.
- R2: Until the first rising edge of `fsync_i` has been seen, `valid_o` stays low whatever arrives on `sdata_i`. That first edge does not set `frame_err_o`.
- R3: Call E0 the rising clock edge at which `fsync_i` is first sampled high after being sampled low. Bit j of slot k is sampled at edge E0 + 1 + 32*k + (23 - j). `valid_o` is high for exactly one cycle, and that cycle follows the edge that samples bit 0 of the slot.
- R4: `sample_o` holds the 24 bits of the slot, with the first serial bit at bit 23. Slot bits 24 to 31 have no effect on any output.
- R5: With `dual_rate_i` = 0 the frame length is 256 clocks. The frame carries channel indices 0 to 7 in slot order, and index n stands for channel n+1.
- R6: With `dual_rate_i` = 1 the frame length is 128 clocks, and only channel indices 0 to 3 are produced. The rate sampled at the edge that registers a frame-sync edge decides the length that this edge is checked against.
- R7: A rising edge of `fsync_i` that comes exactly one frame length after the previous one leaves `frame_err_o` unchanged. An edge at any other position sets `frame_err_o`, which then stays 1 until reset, and the slot count restarts so that the next sample follows R3 from the new edge.
- R8: A falling edge of `fsync_i` inside a frame has no effect on the samples or on the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; data is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_rate_i | input | 1 | 0 = single rate (256-clock frame), 1 = dual rate (128-clock frame) |
| fsync_i | input | 1 | Frame sync; a rising edge marks a frame start |
| sdata_i | input | 1 | Serial audio data |
| sample_o | output | 24 | Received sample, first serial bit at bit 23 |
| chan_o | output | 3 | Zero-based channel index of `sample_o` |
| valid_o | output | 1 | One-cycle strobe: `sample_o`/`chan_o` are new |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
The bench changes every input on a falling clock edge, once per bit position. It then checks the previous position's expectation at the next falling edge. Each check therefore lands one register stage after the rising edge that sampled bit 0 of a slot, which is exactly the cycle in which R3 places `valid_o`, and the same check demands that no valid appears in any other cycle. A framing error is registered at the edge that sees the bad sync, so `frame_err_o` is read only after that edge and is read again a full frame later to confirm that it stays set.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_DUAL   = 1'b1
  } rate_e;
endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8,
  parameter int CNT_W  = $clog2(SLOT_W * SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rate_e            rate_i,
  input  logic             fsync_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             locked_o,
  output logic             sync_o,
  output logic             frame_err_o
);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SLOT_W * SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(SLOT_W * SLOTS / 2 - 1);

  logic             fsync_q;
  logic [CNT_W-1:0] pos_q;
  logic             locked_q;
  logic             err_q;
  logic [CNT_W-1:0] last;

  assign last   = (rate_i == RATE_DUAL) ? LAST_D : LAST_S;
  assign sync_o = fsync_i & ~fsync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsync_q  <= 1'b1;  // a line held high at reset is not a frame start
      pos_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      fsync_q <= fsync_i;
      if (sync_o) begin
        pos_q    <= '0;
        locked_q <= 1'b1;
        if (locked_q && pos_q != last) err_q <= 1'b1;
      end else if (locked_q) begin
        pos_q <= (pos_q >= last) ? '0 : pos_q + 1'b1;
      end
    end
  end

  assign pos_o       = pos_q;
  assign locked_o    = locked_q;
  assign frame_err_o = err_q;

  assert_err_sticky_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);

  assert_no_err_unlocked_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |=> !frame_err_o);
endmodule

// File: rtl/tdm_rx_slot.sv
module tdm_rx_slot
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int CNT_W    = $clog2(SLOT_W * SLOTS),
  parameter int CH_W     = $clog2(SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  rate_e               rate_i,
  input  logic [CNT_W-1:0]    pos_i,
  input  logic                locked_i,
  input  logic                sync_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [CH_W-1:0]     chan_o,
  output logic                valid_o
);
  localparam int              BIT_W    = $clog2(SLOT_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);
  localparam logic [CH_W-1:0]  HALF     = CH_W'(SLOTS / 2);

  logic [BIT_W-1:0]    bit_idx;
  logic [CH_W-1:0]     slot;
  logic                active;
  logic [SAMPLE_W-2:0] shift_q;

  assign bit_idx = pos_i[BIT_W-1:0];
  assign slot    = pos_i[CNT_W-1:BIT_W];
  assign active  = locked_i && !sync_i && ((rate_i == RATE_SINGLE) || (slot < HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      sample_o <= '0;
      chan_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (active && bit_idx < LAST_BIT) shift_q <= {shift_q[SAMPLE_W-3:0], sdata_i};
      if (active && bit_idx == LAST_BIT) begin
        sample_o <= {shift_q, sdata_i};
        chan_o   <= slot;
        valid_o  <= 1'b1;
      end
    end
  end

  assert_one_shot_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_dual_chan_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == RATE_DUAL) |=> (!valid_o || chan_o < HALF));

  assert_quiet_unlocked_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> !valid_o);
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dual_rate_i,
  input  logic                     fsync_i,
  input  logic                     sdata_i,
  output logic [SAMPLE_W-1:0]      sample_o,
  output logic [$clog2(SLOTS)-1:0] chan_o,
  output logic                     valid_o,
  output logic                     frame_err_o
);
  localparam int CNT_W = $clog2(SLOT_W * SLOTS);
  localparam int CH_W  = $clog2(SLOTS);

  rate_e            rate;
  logic [CNT_W-1:0] pos;
  logic             locked;
  logic             sync;

  assign rate = rate_e'(dual_rate_i);

  tdm_rx_sync #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_i     (rate),
    .fsync_i    (fsync_i),
    .pos_o      (pos),
    .locked_o   (locked),
    .sync_o     (sync),
    .frame_err_o(frame_err_o)
  );

  tdm_rx_slot #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS),
                .CNT_W(CNT_W), .CH_W(CH_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate),
    .pos_i   (pos),
    .locked_i(locked),
    .sync_i  (sync),
    .sdata_i (sdata_i),
    .sample_o(sample_o),
    .chan_o  (chan_o),
    .valid_o (valid_o)
  );
endmodule

// File: tb/tdm_rx_tb.sv
module tdm_rx_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dual_rate_i = 1'b0;
  logic        fsync_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic [23:0] sample_o;
  logic [2:0]  chan_o;
  logic        valid_o;
  logic        frame_err_o;

  int run_cnt = 0;
  int fail_cnt = 0;
  int valid_seen = 0;
  bit done = 0;

  logic        rate_next = 1'b0;
  string       chan_req = "R5";
  bit          pv = 0;
  logic [23:0] ps = '0;
  logic [2:0]  pc = '0;

  tdm_rx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dual_rate_i(dual_rate_i), .fsync_i(fsync_i),
    .sdata_i(sdata_i), .sample_o(sample_o), .chan_o(chan_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o)
  );

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) if (valid_o) valid_seen++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    run_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] smp(input int seed, input int ch);
    case (seed)
      0: smp = 24'hFFFFFF;
      1: smp = 24'h000000;
      2: smp = 24'h800001 ^ 24'(ch << 4);
      default: smp = 24'(seed * 32'h9E3779 + ch * 32'h2545F1);
    endcase
  endfunction

  // checks the previous position's result, then drives the next position
  task automatic drive_bit(input logic fs, input logic d, input bit ev,
                           input logic [23:0] es, input logic [2:0] ec);
    @(negedge clk_i);
    if (pv || valid_o) begin
      chk(valid_o == pv, "R3 valid timing", 32'(valid_o), 32'(pv));
      if (pv && valid_o) begin
        chk(sample_o == ps, "R4 sample", 32'(sample_o), 32'(ps));
        chk(chan_o == pc, chan_req, 32'(chan_o), 32'(pc));
      end
    end
    fsync_i = fs;
    sdata_i = d;
    dual_rate_i = rate_next;
    pv = ev;
    ps = es;
    pc = ec;
  endtask

  // sync cycle, then positions 0..len-2; fsync falls mid-frame (R8)
  task automatic frame(input bit dual, input int seed, input int len);
    drive_bit(1'b1, 1'b1, 1'b0, '0, '0);
    rate_next = dual;
    chan_req = dual ? "R6 chan" : "R5 chan";
    for (int p = 0; p <= len - 2; p++) begin
      int s = p / 32;
      int b = p % 32;
      logic [23:0] w = smp(seed, s);
      logic d = (b < 24) ? w[23 - b] : 1'b1;
      drive_bit(p < len / 2, d, b == 23, w, 3'(s));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fail_cnt++;
      run_cnt++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", run_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 valid in reset", 32'(valid_o), 0);
    chk(frame_err_o == 1'b0, "R1 err in reset", 32'(frame_err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 valid after reset", 32'(valid_o), 0);
    chk(frame_err_o == 1'b0, "R1 err after reset", 32'(frame_err_o), 0);

    // R2: data without frame sync
    for (int i = 0; i < 40; i++) drive_bit(1'b0, 1'(i % 3), 1'b0, '0, '0);
    chk(valid_seen == 0, "R2 no output before sync", 32'(valid_seen), 0);

    // R5 single rate, R4 fill bits driven high
    for (int f = 0; f < 3; f++) frame(1'b0, f, 256);
    chk(frame_err_o == 1'b0, "R2/R7 err after good single frames", 32'(frame_err_o), 0);

    // R6 dual rate
    for (int f = 3; f < 6; f++) frame(1'b1, f, 128);
    chk(frame_err_o == 1'b0, "R7 err after good dual frames", 32'(frame_err_o), 0);
    frame(1'b0, 9, 256);
    chk(frame_err_o == 1'b0, "R7 err after rate change", 32'(frame_err_o), 0);

    // R7: short frame, then resync
    frame(1'b0, 6, 100);
    chk(frame_err_o == 1'b0, "R7 err before bad sync", 32'(frame_err_o), 0);
    frame(1'b0, 7, 256);
    chk(frame_err_o == 1'b1, "R7 err after bad sync", 32'(frame_err_o), 1);
    frame(1'b0, 8, 256);
    drive_bit(1'b0, 1'b0, 1'b0, '0, '0);
    chk(frame_err_o == 1'b1, "R7 err sticky", 32'(frame_err_o), 1);

    // R1: reset clears the flag
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(frame_err_o == 1'b0, "R1 err cleared by reset", 32'(frame_err_o), 0);
    pv = 0;
    frame(1'b1, 10, 128);
    frame(1'b1, 11, 128);
    drive_bit(1'b0, 1'b0, 1'b0, '0, '0);
    chk(frame_err_o == 1'b0, "R2 first sync after reset no err", 32'(frame_err_o), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", run_cnt, fail_cnt);
    $finish;
  end
endmodule